// File: doc/BRIEF.md
# Eight-Channel Bus-Master Transfer Engine

This block is a bus master that moves bytes between a wide memory-side space and a narrow register-side space. The wide side takes a 24-bit address (ROM or work RAM) and the narrow side an 8-bit register offset. Each of its eight channels is set up through a write-only register port. It then runs in one of two ways. In block mode, the CPU arms the channels and stays frozen until they have all drained. In line mode, each armed channel sends a short burst, read from an in-memory table, at the start of every horizontal blank.

One byte moves per clock cycle. The engine drives the strobes of both sides in the same cycle, so the read data of one side passes straight through to the write data of the other. When several channels want the bus, a line-mode burst always goes first, and a lower channel number always wins over a higher one. A block transfer that is cut into by a line burst stops between two bytes and carries on from where it stopped.

Top module: `dma8_engine`

## Requirements
- R1: After reset, no strobe is active, `cpu_stall` is low, and no channel is armed in either mode.
- R2: A register write with `reg_addr[7]`=0 reaches channel `reg_addr[6:4]` at index `reg_addr[3:0]`. The indices are: 0 config, 1 narrow base, 2/3/4 wide pointer low/high/bank, 5/6 count low/high, 8/9 table pointer low/high, 10 line count. Address 0x80 writes the block-mode arm mask and 0x81 the line-mode arm mask; bit n of each mask is channel n.
- R3: Config bit 7 sets the direction. With 0, `a_rd` and `b_wr` pulse together and `b_wdata` equals `a_rdata`. With 1, `b_rd` and `a_wr` pulse together and `a_wdata` equals `b_rdata`.
- R4: In block mode the low 16 bits of the wide pointer change after each byte while the bank stays the same. Config bit 3 = 1 holds the pointer. Otherwise config bit 4 = 0 adds 1 and bit 4 = 1 subtracts 1, wrapping within 16 bits.
- R5: The block-mode narrow address for byte k is base+d. Mode (config bits 2:0) 0 and 2 give d=0. Mode 1 gives d=k mod 2. Mode 3 gives d=(k/2) mod 2. Mode 4 gives d=k mod 4. Modes 5 to 7 behave as mode 0.
- R6: A block-mode channel moves exactly `count` bytes, and a count of 0 moves 65536 bytes. Its arm bit then clears and the channel stays silent.
- R7: `cpu_stall` is high whenever a byte moves, and it stays high while any block-mode arm bit is set or a line burst is pending. It returns low once everything has drained.
- R8: Among block-mode channels, the lowest armed channel number moves every byte until it has finished.
- R9: Line bursts start only on a rising edge of `hblank`, and only for line-armed channels whose line count is nonzero.
- R10: A line burst is 1 byte long in mode 0, 2 bytes in modes 1 and 2, and 4 bytes in modes 3 and 4. Its narrow addresses follow base+d with the R5 offset rule, where k counts from 0 within the line.
- R11: The wide address of a line burst is {bank, table pointer}, and the table pointer goes up by 1 per byte across lines. The line count drops by 1 per burst, and at zero the line-mode arm bit clears.
- R12: A pending line burst takes the bus ahead of any block-mode byte. The interrupted block transfer resumes at the next pointer value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (R2) |
| reg_wdata | input | 8 | Register write data |
| hblank | input | 1 | Horizontal blank level |
| cpu_stall | output | 1 | Holds the CPU while transfers are owed |
| a_addr | output | 24 | Wide-side address |
| a_rd | output | 1 | Wide-side read strobe |
| a_wr | output | 1 | Wide-side write strobe |
| a_wdata | output | 8 | Wide-side write data |
| a_rdata | input | 8 | Wide-side read data, valid in the same cycle |
| b_addr | output | 8 | Narrow-side register offset |
| b_rd | output | 1 | Narrow-side read strobe |
| b_wr | output | 1 | Narrow-side write strobe |
| b_wdata | output | 8 | Narrow-side write data |
| b_rdata | input | 8 | Narrow-side read data, valid in the same cycle |

## Verification
The bench runs every mode in both transfer kinds and compares each narrow address with the offset tables. A mixed-up pattern would put mode 3 bytes on alternating registers, or would give a line burst the wrong length. A count of zero must move 65536 bytes; a design that treats it as nothing, or as one byte, stops early. A pointer decrementing from 0x0001 must wrap to 0xFFFF without touching the bank, and a burst fired into a running block transfer must sit as one contiguous run in the middle of it, with no lost or repeated pointer values. Two block channels armed together must drain in channel-number order, and a line-armed channel must stay silent until a blank edge and again after its last line.

// File: rtl/dma8_pkg.sv
package dma8_pkg;

   // Stored part of a channel's config byte (bits 6:5 are not kept)
   typedef struct packed {
      logic       dir;    // 0: wide -> narrow, 1: narrow -> wide
      logic       down;   // pointer steps downward
      logic       hold;   // pointer does not move
      logic [2:0] mode;   // narrow address pattern
   } chan_cfg_t;

   localparam logic [3:0] IX_CFG   = 4'd0;
   localparam logic [3:0] IX_BOFF  = 4'd1;
   localparam logic [3:0] IX_ALO   = 4'd2;
   localparam logic [3:0] IX_AHI   = 4'd3;
   localparam logic [3:0] IX_BANK  = 4'd4;
   localparam logic [3:0] IX_CLO   = 4'd5;
   localparam logic [3:0] IX_CHI   = 4'd6;
   localparam logic [3:0] IX_TLO   = 4'd8;
   localparam logic [3:0] IX_THI   = 4'd9;
   localparam logic [3:0] IX_LINES = 4'd10;

   localparam logic [7:0] GA_BLOCK_ARM = 8'h80;
   localparam logic [7:0] GA_LINE_ARM  = 8'h81;

   // Narrow-side offset for byte k of a pattern
   function automatic logic [1:0] b_step(input logic [2:0] mode, input logic [1:0] k);
      case (mode)
         3'd1:    b_step = {1'b0, k[0]};
         3'd3:    b_step = {1'b0, k[1]};
         3'd4:    b_step = k;
         default: b_step = 2'd0;
      endcase
   endfunction

   // Bytes per line burst
   function automatic logic [2:0] line_len(input logic [2:0] mode);
      case (mode)
         3'd1, 3'd2: line_len = 3'd2;
         3'd3, 3'd4: line_len = 3'd4;
         default:    line_len = 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/dma8_pick.sv
module dma8_pick #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic          any,
   output logic [IW-1:0] idx
);

   if (N < 1) begin : g_bad_n
      $error("dma8_pick: N must be at least 1");
   end

   // Lowest index wins: scan down so the last hit is the smallest
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
            idx    = IW'(i);
            any    = 1'b1;
         end
      end
   end

   p_gnt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   p_gnt_served_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> ((gnt & req) != '0));

   for (genvar g = 1; g < N; g++) begin : g_low
      p_gnt_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
         gnt[g] |-> (req[g-1:0] == '0));
   end

endmodule

// File: rtl/dma8_chan.sv
module dma8_chan
   import dma8_pkg::*;
#(
   parameter int AW = 24,
   parameter int CW = 16,
   parameter int BW = 8,
   parameter int LW = 8,
   localparam int BKW = AW - 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [3:0]    wr_idx,
   input  logic [7:0]    wr_data,
   input  logic          dma_go,
   input  logic          hdma_go,
   input  logic          step_clr,
   output logic          dir_o,
   output logic [AW-1:0] src_addr,
   output logic [AW-1:0] tbl_addr,
   output logic [BW-1:0] b_addr,
   output logic          dma_last,
   output logic          burst_end,
   output logic          lines_one,
   output logic          lines_zero
);

   if (AW <= 16 || AW > 24) begin : g_bad_aw
      $error("dma8_chan: AW must be 17..24");
   end
   if (CW != 16 || BW != 8 || LW != 8) begin : g_bad_w
      $error("dma8_chan: count, narrow and line widths are byte-programmed");
   end

   chan_cfg_t      cfg;
   logic [BW-1:0]  b_base;
   logic [15:0]    a_ptr;
   logic [BKW-1:0] bank;
   logic [CW-1:0]  cnt;
   logic [15:0]    tbl;
   logic [LW-1:0]  lines;
   logic [1:0]     step;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg    <= '0;
         b_base <= '0;
         a_ptr  <= '0;
         bank   <= '0;
         cnt    <= '0;
         tbl    <= '0;
         lines  <= '0;
         step   <= '0;
      end else begin
         if (dma_go) begin
            if (!cfg.hold) a_ptr <= cfg.down ? a_ptr - 16'd1 : a_ptr + 16'd1;
            cnt  <= cnt - 1'b1;
            step <= step + 2'd1;
         end
         if (hdma_go) begin
            tbl <= tbl + 16'd1;
            if (burst_end) begin
               step  <= '0;
               lines <= lines - 1'b1;
            end else begin
               step  <= step + 2'd1;
            end
         end
         if (step_clr) step <= '0;
         // CPU writes take precedence over engine updates
         if (wr_en) begin
            case (wr_idx)
               IX_CFG:   cfg <= '{dir: wr_data[7], down: wr_data[4],
                                  hold: wr_data[3], mode: wr_data[2:0]};
               IX_BOFF:  b_base      <= wr_data;
               IX_ALO:   a_ptr[7:0]  <= wr_data;
               IX_AHI:   a_ptr[15:8] <= wr_data;
               IX_BANK:  bank        <= wr_data[BKW-1:0];
               IX_CLO:   cnt[7:0]    <= wr_data;
               IX_CHI:   cnt[15:8]   <= wr_data;
               IX_TLO:   tbl[7:0]    <= wr_data;
               IX_THI:   tbl[15:8]   <= wr_data;
               IX_LINES: lines       <= wr_data;
               default: ;
            endcase
         end
      end
   end

   assign dir_o      = cfg.dir;
   assign src_addr   = {bank, a_ptr};
   assign tbl_addr   = {bank, tbl};
   assign b_addr     = b_base + {{(BW-2){1'b0}}, b_step(cfg.mode, step)};
   assign burst_end  = (({1'b0, step}) + 3'd1) == line_len(cfg.mode);
   assign dma_last   = (cnt == CW'(1));
   assign lines_one  = (lines == LW'(1));
   assign lines_zero = (lines == '0);

   p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_go && cfg.hold && !wr_en) |=> $stable(src_addr));

   p_line_dec_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (hdma_go && burst_end && !wr_en) |=> (lines == $past(lines) - 1'b1));

endmodule

// File: rtl/dma8_engine.sv
module dma8_engine
   import dma8_pkg::*;
#(
   parameter int NCH = 8,
   parameter int AW  = 24,
   localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [7:0]    reg_addr,
   input  logic [7:0]    reg_wdata,
   input  logic          hblank,
   output logic          cpu_stall,
   output logic [AW-1:0] a_addr,
   output logic          a_rd,
   output logic          a_wr,
   output logic [7:0]    a_wdata,
   input  logic [7:0]    a_rdata,
   output logic [7:0]    b_addr,
   output logic          b_rd,
   output logic          b_wr,
   output logic [7:0]    b_wdata,
   input  logic [7:0]    b_rdata
);

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("dma8_engine: NCH must be 1..8 (three channel address bits)");
   end

   logic [NCH-1:0] dma_en, hdma_en, hdma_pend;
   logic           hb_q, hb_rise, en_wr, hen_wr;
   logic [NCH-1:0] ch_wr, dma_go, hdma_go, step_clr;
   logic [NCH-1:0] dir_v, last_v, bend_v, lone_v, lzero_v;
   logic [AW-1:0]  src_v  [NCH];
   logic [AW-1:0]  tbl_v  [NCH];
   logic [7:0]     baddr_v[NCH];
   logic [NCH-1:0] h_gnt, d_gnt;
   logic           h_any, d_any, active, dir;
   logic [IW-1:0]  h_idx, d_idx, sel;

   assign hb_rise = hblank & ~hb_q;
   assign en_wr   = reg_wr && (reg_addr == GA_BLOCK_ARM);
   assign hen_wr  = reg_wr && (reg_addr == GA_LINE_ARM);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ch_wr[c]    = reg_wr && !reg_addr[7] && (reg_addr[6:4] == 3'(c));
      assign step_clr[c] = (en_wr && reg_wdata[c]) || (hb_rise && hdma_en[c]);

      dma8_chan #(.AW(AW), .CW(16), .BW(8), .LW(8)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (ch_wr[c]),
         .wr_idx    (reg_addr[3:0]),
         .wr_data   (reg_wdata),
         .dma_go    (dma_go[c]),
         .hdma_go   (hdma_go[c]),
         .step_clr  (step_clr[c]),
         .dir_o     (dir_v[c]),
         .src_addr  (src_v[c]),
         .tbl_addr  (tbl_v[c]),
         .b_addr    (baddr_v[c]),
         .dma_last  (last_v[c]),
         .burst_end (bend_v[c]),
         .lines_one (lone_v[c]),
         .lines_zero(lzero_v[c])
      );
   end

   dma8_pick #(.N(NCH)) u_hpick (
      .clk(clk), .rst_n(rst_n), .req(hdma_pend), .gnt(h_gnt), .any(h_any), .idx(h_idx)
   );
   dma8_pick #(.N(NCH)) u_dpick (
      .clk(clk), .rst_n(rst_n), .req(dma_en), .gnt(d_gnt), .any(d_any), .idx(d_idx)
   );

   // Line bursts pre-empt block transfers at byte granularity
   assign hdma_go = h_gnt;
   assign dma_go  = h_any ? '0 : d_gnt;
   assign active  = h_any | d_any;
   assign sel     = h_any ? h_idx : d_idx;
   assign dir     = dir_v[sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hb_q      <= 1'b0;
         dma_en    <= '0;
         hdma_en   <= '0;
         hdma_pend <= '0;
      end else begin
         hb_q      <= hblank;
         dma_en    <= en_wr  ? reg_wdata[NCH-1:0] : (dma_en  & ~(dma_go & last_v));
         hdma_en   <= hen_wr ? reg_wdata[NCH-1:0] : (hdma_en & ~(hdma_go & bend_v & lone_v));
         hdma_pend <= hb_rise ? (hdma_en & ~lzero_v) : (hdma_pend & ~(hdma_go & bend_v));
      end
   end

   assign cpu_stall = (|dma_en) | (|hdma_pend);
   assign a_addr    = !active ? '0 : (h_any ? tbl_v[sel] : src_v[sel]);
   assign b_addr    = active ? baddr_v[sel] : 8'h00;
   assign a_rd      = active & ~dir;
   assign b_wr      = active & ~dir;
   assign b_rd      = active &  dir;
   assign a_wr      = active &  dir;
   assign b_wdata   = a_rdata;
   assign a_wdata   = b_rdata;

   p_line_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (|hdma_pend) |-> (dma_go == '0));

   p_strobe_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd == b_wr) && (a_wr == b_rd) && !(a_rd && a_wr));

   p_line_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|hdma_pend) |-> $past(hblank));

   p_stall_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd || a_wr) |-> cpu_stall);

   for (genvar c = 0; c < NCH; c++) begin : g_chk
      p_arm_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(dma_en[c]) && !$past(en_wr)) |-> $past(dma_go[c]));
   end

endmodule

// File: tb/tb_dma8_engine.sv
`timescale 1ns/1ps
module tb_dma8_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        hblank = 1'b0;
   logic        cpu_stall;
   logic [23:0] a_addr;
   logic        a_rd, a_wr, b_rd, b_wr;
   logic [7:0]  a_wdata, a_rdata, b_addr, b_wdata, b_rdata;

   always #2.5 clk = ~clk;

   dma8_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .hblank(hblank), .cpu_stall(cpu_stall),
      .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr), .b_wdata(b_wdata), .b_rdata(b_rdata)
   );

   function automatic logic [7:0] afun(input logic [23:0] a);
      return a[7:0] + a[15:8] + a[23:16];
   endfunction

   // Memory models: both sides answer in the same cycle
   assign a_rdata = afun(a_addr);
   assign b_rdata = ~b_addr;

   // {mode, block offsets k0..k7 (2 bits each, k0 in LSBs), burst length, line offsets}
   localparam int NV = 6;
   localparam logic [39:0] VEC [NV] = '{
      {8'd0, 16'h0000, 8'd1, 8'h00},
      {8'd1, 16'h4444, 8'd2, 8'h04},
      {8'd2, 16'h0000, 8'd2, 8'h00},
      {8'd3, 16'h5050, 8'd4, 8'h50},
      {8'd4, 16'hE4E4, 8'd4, 8'hE4},
      {8'd5, 16'h0000, 8'd1, 8'h00}
   };

   int checks = 0, errors = 0;
   int xfer_n = 0, nostall_n = 0, pair_bad = 0;
   logic [23:0] lg_a [256];
   logic [7:0]  lg_b [256];
   logic [7:0]  lg_d [256];
   logic        lg_w [256];

   always @(negedge clk) begin
      if (rst_n && (a_rd || a_wr || b_rd || b_wr)) begin
         lg_a[xfer_n & 255] = a_addr;
         lg_b[xfer_n & 255] = b_addr;
         lg_d[xfer_n & 255] = a_rd ? b_wdata : a_wdata;
         lg_w[xfer_n & 255] = a_wr;
         if (!cpu_stall) nostall_n++;
         if (!((a_rd && b_wr && !a_wr && !b_rd) || (a_wr && b_rd && !a_rd && !b_wr))) pair_bad++;
         xfer_n++;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic wreg(input logic [7:0] ad, input logic [7:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = ad; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   // R2 register layout
   task automatic prog(input int ch, input logic [7:0] cfg, input logic [7:0] bb,
                       input logic [23:0] aa, input logic [15:0] cn,
                       input logic [15:0] tb, input logic [7:0] ln);
      logic [7:0] hi;
      hi = {1'b0, 3'(ch), 4'h0};
      wreg(hi | 8'd0, cfg);
      wreg(hi | 8'd1, bb);
      wreg(hi | 8'd2, aa[7:0]);
      wreg(hi | 8'd3, aa[15:8]);
      wreg(hi | 8'd4, aa[23:16]);
      wreg(hi | 8'd5, cn[7:0]);
      wreg(hi | 8'd6, cn[15:8]);
      wreg(hi | 8'd8, tb[7:0]);
      wreg(hi | 8'd9, tb[15:8]);
      wreg(hi | 8'd10, ln);
   endtask

   task automatic wait_idle();
      do begin @(negedge clk); #1; end while (cpu_stall);
      @(posedge clk); #1;
   endtask

   task automatic hline();
      @(posedge clk); #1; hblank = 1'b1;
      repeat (8) @(posedge clk);
      #1; hblank = 1'b0;
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog: actual=busy expected=idle");
      summary();
      $finish;
   end

   initial begin
      int base, e, h, hpos, j;
      logic [7:0] mode, hlen, hpat, eb;
      logic [15:0] dpat;
      logic [23:0] ea;

      repeat (4) @(posedge clk);
      #1; rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!cpu_stall, "R1", "stall after reset", cpu_stall, 0);
      chk(!(a_rd || a_wr || b_rd || b_wr), "R1", "strobes after reset",
          {a_rd, a_wr, b_rd, b_wr}, 0);
      repeat (3) @(negedge clk);
      chk(xfer_n == 0, "R1", "idle after reset", xfer_n, 0);

      // Block mode: every pattern from the vector table
      for (int v = 0; v < NV; v++) begin
         {mode, dpat, hlen, hpat} = VEC[v];
         prog(0, mode, 8'h10, 24'h011000, 16'd8, 16'h0000, 8'd0);
         base = xfer_n;
         wreg(8'h80, 8'h01);
         chk(cpu_stall, "R7", "stall once armed", cpu_stall, 1);
         wait_idle();
         repeat (4) @(posedge clk);
         chk(xfer_n - base == 8, "R6", "block byte count", xfer_n - base, 8);
         for (int k = 0; k < 8; k++) begin
            e  = (base + k) & 255;
            eb = 8'h10 + 8'(dpat[2*k +: 2]);
            ea = 24'h011000 + 24'(k);
            chk(lg_b[e] == eb, "R5", "block narrow address", lg_b[e], eb);
            chk(lg_a[e] == ea, "R4", "block wide address", lg_a[e], ea);
            chk(lg_d[e] == afun(ea) && !lg_w[e], "R3", "wide to narrow data",
                lg_d[e], afun(ea));
         end
      end

      // Line mode: every pattern from the vector table
      for (int v = 0; v < NV; v++) begin
         {mode, dpat, hlen, hpat} = VEC[v];
         prog(4, mode, 8'h40, 24'h7E0000, 16'd0, 16'h2000, 8'd2);
         base = xfer_n;
         wreg(8'h81, 8'h10);
         repeat (6) @(posedge clk);
         #1;
         chk(xfer_n == base, "R9", "no burst before blank", xfer_n - base, 0);
         hline();
         chk(xfer_n - base == int'(hlen), "R10", "burst length", xfer_n - base, hlen);
         hline();
         hline();
         chk(xfer_n - base == 2 * int'(hlen), "R11", "stops at line count zero",
             xfer_n - base, 2 * hlen);
         for (int k = 0; k < 2 * int'(hlen); k++) begin
            e  = (base + k) & 255;
            eb = 8'h40 + 8'(hpat[2*(k % int'(hlen)) +: 2]);
            ea = 24'h7E2000 + 24'(k);
            chk(lg_b[e] == eb, "R10", "line narrow address", lg_b[e], eb);
            chk(lg_a[e] == ea, "R11", "table address", lg_a[e], ea);
         end
      end

      // R4 decrement with wrap inside the bank
      prog(0, 8'h10, 8'h05, 24'h050001, 16'd3, 16'h0000, 8'd0);
      base = xfer_n;
      wreg(8'h80, 8'h01);
      wait_idle();
      chk(lg_a[(base) & 255] == 24'h050001, "R4", "decrement first", lg_a[base & 255], 24'h050001);
      chk(lg_a[(base + 1) & 255] == 24'h050000, "R4", "decrement second", lg_a[(base+1) & 255], 24'h050000);
      chk(lg_a[(base + 2) & 255] == 24'h05FFFF, "R4", "decrement wrap", lg_a[(base+2) & 255], 24'h05FFFF);

      // R4 held pointer
      prog(0, 8'h08, 8'h05, 24'h060042, 16'd3, 16'h0000, 8'd0);
      base = xfer_n;
      wreg(8'h80, 8'h01);
      wait_idle();
      for (int k = 0; k < 3; k++)
         chk(lg_a[(base + k) & 255] == 24'h060042, "R4", "held pointer",
             lg_a[(base + k) & 255], 24'h060042);

      // R3 narrow to wide direction, mode 1
      prog(0, 8'h81, 8'h22, 24'h001000, 16'd4, 16'h0000, 8'd0);
      base = xfer_n;
      wreg(8'h80, 8'h01);
      wait_idle();
      chk(xfer_n - base == 4, "R6", "reverse byte count", xfer_n - base, 4);
      for (int k = 0; k < 4; k++) begin
         e  = (base + k) & 255;
         eb = 8'h22 + 8'(k % 2);
         chk(lg_w[e] && lg_b[e] == eb, "R3", "reverse narrow address", lg_b[e], eb);
         chk(lg_d[e] == ~eb, "R3", "narrow to wide data", lg_d[e], ~eb);
      end

      // R8 lowest channel first (channel 2 and 5 armed together, R2 decode)
      prog(5, 8'h00, 8'h50, 24'h000500, 16'd2, 16'h0000, 8'd0);
      prog(2, 8'h00, 8'h28, 24'h000200, 16'd2, 16'h0000, 8'd0);
      base = xfer_n;
      wreg(8'h80, 8'h24);
      wait_idle();
      chk(xfer_n - base == 4, "R8", "two channel total", xfer_n - base, 4);
      for (int k = 0; k < 4; k++) begin
         eb = (k < 2) ? 8'h28 : 8'h50;
         chk(lg_b[(base + k) & 255] == eb, "R8 R2", "channel order",
             lg_b[(base + k) & 255], eb);
      end

      // R12 burst cutting into a block transfer
      prog(3, 8'h01, 8'h70, 24'h000000, 16'd0, 16'h4000, 8'd1);
      wreg(8'h81, 8'h08);
      prog(1, 8'h00, 8'h60, 24'h003000, 16'd6, 16'h0000, 8'd0);
      base = xfer_n;
      wreg(8'h80, 8'h02);
      while (xfer_n - base < 2) @(negedge clk);
      @(posedge clk); #1; hblank = 1'b1;
      wait_idle();
      hblank = 1'b0;
      chk(xfer_n - base == 8, "R12", "mixed total", xfer_n - base, 8);
      h = 0; hpos = -1; j = 0;
      for (int k = 0; k < 8; k++) begin
         e = (base + k) & 255;
         if (lg_b[e] >= 8'h70) begin
            if (hpos < 0) hpos = k;
            h++;
         end else begin
            ea = 24'h003000 + 24'(j);
            chk(lg_a[e] == ea, "R12", "block resumes in order", lg_a[e], ea);
            j++;
         end
      end
      chk(h == 2 && hpos >= 2 && hpos <= 5, "R12", "burst inside block run", hpos, 3);
      if (hpos >= 0) begin
         chk(lg_b[(base + hpos) & 255] == 8'h70 && lg_b[(base + hpos + 1) & 255] == 8'h71,
             "R12", "burst contiguous", lg_b[(base + hpos + 1) & 255], 8'h71);
      end

      // R6 count of zero means 65536 bytes
      prog(0, 8'h00, 8'h01, 24'h020000, 16'd0, 16'h0000, 8'd0);
      base = xfer_n;
      wreg(8'h80, 8'h01);
      wait_idle();
      repeat (4) @(posedge clk);
      chk(xfer_n - base == 65536, "R6", "zero count length", xfer_n - base, 65536);
      chk(lg_a[(base + 65535) & 255] == 24'h02FFFF, "R6", "zero count last address",
          lg_a[(base + 65535) & 255], 24'h02FFFF);

      chk(nostall_n == 0, "R7", "bytes moved without stall", nostall_n, 0);
      chk(pair_bad == 0, "R3", "strobe pairing", pair_bad, 0);
      chk(!cpu_stall, "R7", "stall released at end", cpu_stall, 0);

      summary();
      $finish;
   end

endmodule